// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Engine

This block computes one output element of a linear layer. It takes a vector of signed 8-bit activations and a matching vector of ternary weights, each weight in {-1, 0, +1}. It uses no per-element multiplier. One activation and one 2-bit weight code arrive per cycle, qualified by a valid flag, and a last flag marks the final element of the vector.

For each element the weight chooses what happens:
- a weight of +1 adds the activation to a signed accumulator;
- a weight of -1 subtracts it;
- a weight of 0 leaves the accumulator alone.

After the last element, the block multiplies the finished sum once by a per-layer scale. The scale is unsigned fixed point with 8 fractional bits. The block then rounds the product, saturates it to a 16-bit signed result, and presents it for one cycle. With each result it also reports how many zero weights were skipped in that vector. The accumulator clears by itself, so vectors may follow each other with no idle cycle between them.

Top module: `tern_dot_engine`

## Requirements
- R1: Weight codes are 2'b01 = +1, 2'b11 = -1 and 2'b00 = 0. A +1 weight adds the signed activation to the sum, and a -1 weight subtracts it.
- R2: An element with a zero weight, or any cycle with `in_valid` low, leaves the sum unchanged.
- R3: The result is floor((sum * scale + 128) / 256). Here `scale` is unsigned with 8 fractional bits, and it is sampled with the element flagged last. Halves therefore round toward positive infinity.
- R4: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R5: `out_valid` is high for exactly one cycle. That cycle is the one right after the clock edge that samples the element carrying `in_last`. At all other times `out_valid` is low.
- R6: The sum and the zero count restart from zero after every vector. Vectors may be sent back to back with no idle cycle.
- R7: `out_zeros` gives the number of elements in the vector whose code was 2'b00 or 2'b10.
- R8: Code 2'b10 is illegal and contributes nothing to the sum. The first valid element carrying it sets `code_err`, which then stays high until reset.
- R9: While reset is active, and in the cycle after it, `out_valid` and `code_err` are low and `out_data` is zero.
- R10: A vector of up to MAX_LEN elements (default 64) produces its exact sum, with no wraparound, including when every element is -128 or 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element qualifier |
| in_last | input | 1 | Marks the final element of a vector |
| in_act | input | 8 | Signed activation |
| in_wcode | input | 2 | Ternary weight code |
| scale | input | 16 | Per-layer scale, unsigned, 8 fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Scaled, rounded, saturated signed result |
| out_zeros | output | 7 | Zero weights skipped in the vector |
| code_err | output | 1 | Sticky illegal-code flag |

## Verification
The assertions assume two things about the inputs:
- no vector is longer than MAX_LEN elements;
- `scale` is stable when the last element is sampled.

The bench keeps every vector at or below MAX_LEN elements. It drives the scale once at the start of each vector and changes it only after that vector's last element has been sampled. Within those limits the bench covers every activation with every legal code, and it tests full-length vectors at both extremes of the activation range.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef enum logic [1:0] {
    WC_ZERO = 2'b00,
    WC_POS  = 2'b01,
    WC_BAD  = 2'b10,
    WC_NEG  = 2'b11
  } wcode_e;
endpackage

// File: rtl/tern_select.sv
module tern_select #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 16
) (
  input  logic [ACT_W-1:0]        act,
  input  logic [1:0]              code,
  output logic signed [ACC_W-1:0] contrib,
  output logic                    skip,
  output logic                    bad
);
  import tern_pkg::*;
  logic signed [ACC_W-1:0] act_ext;

  always_comb begin
    act_ext = ACC_W'($signed(act));
    contrib = '0;
    skip    = 1'b0;
    bad     = 1'b0;
    case (wcode_e'(code))
      WC_POS:  contrib = act_ext;
      WC_NEG:  contrib = -act_ext;
      WC_BAD:  begin skip = 1'b1; bad = 1'b1; end
      default: skip = 1'b1;
    endcase
  end
endmodule

// File: rtl/tern_accum.sv
module tern_accum #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic                    last,
  input  logic signed [ACC_W-1:0] contrib,
  input  logic                    skip,
  output logic signed [ACC_W-1:0] vec_sum,
  output logic [CNT_W-1:0]        vec_zeros,
  output logic                    vec_fire
);
  logic signed [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0]        zc_q;

  always_comb begin
    vec_sum   = skip ? acc_q : acc_q + contrib;
    vec_zeros = zc_q + CNT_W'(skip);
    vec_fire  = valid && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      zc_q  <= '0;
    end else if (valid) begin
      if (last) begin
        acc_q <= '0;
        zc_q  <= '0;
      end else begin
        if (!skip) acc_q <= vec_sum;
        zc_q <= vec_zeros;
      end
    end
  end
endmodule

// File: rtl/tern_scaler.sv
module tern_scaler #(
  parameter int ACC_W   = 16,
  parameter int CNT_W   = 7,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 8,
  parameter int OUT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] sum,
  input  logic [CNT_W-1:0]        zeros,
  input  logic [SCALE_W-1:0]      scale,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data,
  output logic [CNT_W-1:0]        out_zeros
);
  localparam int PW = ACC_W + SCALE_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] OMAX = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] OMIN = -(PW'(1) <<< (OUT_W - 1));

  logic signed [PW-1:0] sum_ext, scl_ext, prod, shf;
  logic [OUT_W-1:0]     sat;

  always_comb begin
    sum_ext = PW'(sum);
    scl_ext = $signed({{(PW-SCALE_W){1'b0}}, scale});
    prod    = sum_ext * scl_ext;
    shf     = (prod + HALF) >>> FRAC;
    if (shf > OMAX)      sat = OMAX[OUT_W-1:0];
    else if (shf < OMIN) sat = OMIN[OUT_W-1:0];
    else                 sat = shf[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_zeros <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data  <= sat;
        out_zeros <= zeros;
      end
    end
  end
endmodule

// File: rtl/tern_dot_engine.sv
module tern_dot_engine #(
  parameter int ACT_W   = 8,
  parameter int MAX_LEN = 64,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 8,
  parameter int OUT_W   = 16,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int ACC_W  = ACT_W + CNT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [ACT_W-1:0]   in_act,
  input  logic [1:0]         in_wcode,
  input  logic [SCALE_W-1:0] scale,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data,
  output logic [CNT_W-1:0]   out_zeros,
  output logic               code_err
);
  logic signed [ACC_W-1:0] contrib, vec_sum;
  logic [CNT_W-1:0]        vec_zeros;
  logic                    skip, bad, vec_fire;

  tern_select #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_sel (
    .act(in_act), .code(in_wcode), .contrib(contrib), .skip(skip), .bad(bad)
  );

  tern_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .valid(in_valid), .last(in_last),
    .contrib(contrib), .skip(skip),
    .vec_sum(vec_sum), .vec_zeros(vec_zeros), .vec_fire(vec_fire)
  );

  tern_scaler #(.ACC_W(ACC_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W),
                .FRAC(FRAC), .OUT_W(OUT_W)) u_scl (
    .clk(clk), .rst(rst), .fire(vec_fire), .sum(vec_sum), .zeros(vec_zeros),
    .scale(scale), .out_valid(out_valid), .out_data(out_data),
    .out_zeros(out_zeros)
  );

  always_ff @(posedge clk) begin
    if (rst)                  code_err <= 1'b0;
    else if (in_valid && bad) code_err <= 1'b1;
  end
endmodule

// File: rtl/tern_dot_chk.sv
module tern_dot_chk #(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic [1:0]       in_wcode,
  input logic             out_valid,
  input logic [CNT_W-1:0] out_zeros,
  input logic             code_err
);
  int elem_cnt;

  always_ff @(posedge clk) begin
    if (rst) elem_cnt <= 0;
    else if (in_valid) elem_cnt <= in_last ? 0 : elem_cnt + 1;
  end

  p_len_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> elem_cnt < MAX_LEN);

  p_valid_follows_last_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> out_valid);

  p_valid_only_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last));

  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_wcode == 2'b10) |=> code_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err);

  p_zero_bound_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(out_zeros) <= MAX_LEN);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && !code_err));
endmodule

bind tern_dot_engine tern_dot_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .in_wcode(in_wcode), .out_valid(out_valid), .out_zeros(out_zeros),
  .code_err(code_err)
);

// File: tb/tern_dot_engine_tb.sv
module tern_dot_engine_tb;
  localparam int MAXL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_act = '0;
  logic [1:0]  in_wcode = '0;
  logic [15:0] scale = 16'h0100;
  logic        out_valid;
  logic [15:0] out_data;
  logic [6:0]  out_zeros;
  logic        code_err;

  int checks = 0, errors = 0;
  int exp_d[$];
  int exp_z[$];
  string exp_t[$];
  int va[MAXL];
  logic [1:0] vw[MAXL];

  always #4 clk = ~clk;

  tern_dot_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_act(in_act), .in_wcode(in_wcode), .scale(scale),
    .out_valid(out_valid), .out_data(out_data), .out_zeros(out_zeros),
    .code_err(code_err)
  );

  task automatic chk(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Result monitor: R3/R4 data, R7 zero count, R5 single-cycle strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_d.size() == 0) begin
        chk("R5 unexpected out_valid", 1, 0);
      end else begin
        string t;
        t = exp_t.pop_front();
        chk({t, " data"}, longint'($signed(out_data)), exp_d.pop_front());
        chk("R7 zeros", out_zeros, exp_z.pop_front());
      end
    end
  end

  function automatic int model(int len, int sc, output int zc);
    longint s = 0, p, r;
    zc = 0;
    for (int i = 0; i < len; i++) begin
      if (vw[i] == 2'b01)      s += va[i];
      else if (vw[i] == 2'b11) s -= va[i];
      else                     zc++;
    end
    p = s * sc;
    r = (p + 128) >>> 8;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // called just after a negedge; returns just after a negedge
  task automatic run_vec(int len, int sc, string tag, bit gaps);
    int z, e;
    e = model(len, sc, z);
    scale = 16'(sc);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_act   = 8'(va[i]);
      in_wcode = vw[i];
      in_last  = (i == len - 1);
      if (in_last) begin
        exp_d.push_back(e); exp_z.push_back(z); exp_t.push_back(tag);
      end
      @(negedge clk);
      if (gaps && !in_last) begin
        in_valid = 1'b0;
        in_act   = 8'h7f;
        in_wcode = 2'b01;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid in reset", out_valid, 0);
    chk("R9 code_err in reset", code_err, 0);
    chk("R9 out_data in reset", out_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 out_valid after reset", out_valid, 0);

    // R1 R2: every activation with every legal code, single-element vectors back to back
    for (int a = -128; a < 128; a++) begin
      for (int c = 0; c < 3; c++) begin
        va[0] = a;
        vw[0] = (c == 0) ? 2'b00 : (c == 1) ? 2'b01 : 2'b11;
        run_vec(1, 256, (c == 0) ? "R2" : "R1", 1'b0);
      end
    end
    @(negedge clk);
    chk("R5 out_valid low after stream", out_valid, 0);

    // R3 rounding with a half scale, including negative halves
    for (int a = -4; a <= 4; a++) begin
      va[0] = a; vw[0] = 2'b01;
      run_vec(1, 128, "R3 half", 1'b0);
    end

    // R6 R3 multi-element vectors, random lengths, scales, back to back and with gaps
    for (int n = 0; n < 300; n++) begin
      int len;
      len = 1 + int'($urandom % MAXL);
      for (int i = 0; i < len; i++) begin
        int c;
        va[i] = int'($urandom % 256) - 128;
        c = int'($urandom % 3);
        vw[i] = (c == 0) ? 2'b00 : (c == 1) ? 2'b01 : 2'b11;
      end
      run_vec(len, int'($urandom % 65536), "R6", n[2]);
    end

    // R4 positive saturation and R10 exact extremes at full length
    for (int i = 0; i < MAXL; i++) begin va[i] = 127; vw[i] = 2'b01; end
    run_vec(MAXL, 16'hFFFF, "R4 pos", 1'b0);
    run_vec(MAXL, 256, "R10 max", 1'b0);
    for (int i = 0; i < MAXL; i++) begin va[i] = -128; vw[i] = 2'b01; end
    run_vec(MAXL, 16'hFFFF, "R4 neg", 1'b0);
    run_vec(MAXL, 256, "R10 min", 1'b0);
    for (int i = 0; i < MAXL; i++) begin va[i] = -128; vw[i] = 2'b11; end
    run_vec(MAXL, 256, "R10 negated", 1'b0);

    // R7 all-zero weights at full length
    for (int i = 0; i < MAXL; i++) begin va[i] = 100; vw[i] = 2'b00; end
    run_vec(MAXL, 256, "R7 all zero", 1'b0);

    @(negedge clk);
    chk("R8 code_err before illegal", code_err, 0);
    // R8 illegal code contributes nothing, counts as zero, sets sticky flag
    va[0] = 50; vw[0] = 2'b01;
    va[1] = 99; vw[1] = 2'b10;
    va[2] = 7;  vw[2] = 2'b11;
    run_vec(3, 256, "R8 illegal", 1'b0);
    @(negedge clk);
    chk("R8 code_err set", code_err, 1);
    va[0] = 10; vw[0] = 2'b01;
    run_vec(1, 256, "R8 after", 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 code_err sticky", code_err, 1);

    repeat (3) @(negedge clk);
    chk("R5 all results seen", exp_d.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule